// File: doc/BRIEF.md
# Pipelined Logarithmic Barrel Rotator

This block rotates a data word by a variable amount. The amount is given on a count input. A direction input chooses a rotation toward the most significant end (left) or toward the least significant end (right). The datapath is a chain of layers, one for each count bit. Layer k is a row of 2:1 multiplexers that either rotates the word right by 2^k positions or passes it through unchanged. The count therefore never passes through an adder.

A left rotation uses the same right-rotate chain. The word is bit-reversed on entry when left is requested, and the result is bit-reversed again in the final stage. A build-time parameter, `PIPELINE`, chooses between two forms:

- **Pipelined:** a register after every layer.
- **Unpipelined:** a single register after the whole chain.

A valid flag travels with each word, as do the count bits and the direction bit that later layers still need. As a result, a new word can enter on every cycle. The block has no state machine. Its only sequencing is the fixed-depth pipeline of valid flags.

Top module: `rot_barrel`

## Requirements
- R1: With `in_left` = 0 (right), result bit i equals input bit ((i + `in_count`) mod 32).
- R2: With `in_left` = 1 (left), result bit ((i + `in_count`) mod 32) equals input bit i.
- R3: A count of 0 returns the input word unchanged in both directions.
- R4: A word presented with `in_valid` high is sampled at a rising edge. Its result appears on `out_data`, with `out_valid` high, exactly LAT rising edges later. LAT is 5 when `PIPELINE` = 1 and 1 when `PIPELINE` = 0. Cycles with `in_valid` low produce `out_valid` low in the matching output slot.
- R5: A word may be accepted on every cycle. Each word is rotated by its own count and direction, even when neighbouring words in flight use different ones.
- R6: A synchronous active-high `rst` clears every in-flight valid flag. `out_valid` is low from the first edge with `rst` high, and no word accepted before that edge is ever delivered.
- R7: Rotation preserves the number of one bits in the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Word on `in_data` is to be rotated |
| in_data | input | 32 | Word to rotate |
| in_count | input | 5 | Rotation amount, 0 to 31 |
| in_left | input | 1 | 1 = rotate left, 0 = rotate right |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | 32 | Rotated word |

## Verification
On every cycle, the checker confirms three things:
- the output valid flag matches the input valid flag delayed by the latency, and reset clears it;
- a zero count gives back the delayed input word;
- a count of one gives the expected single-position rotation in either direction, and the one-bit count is preserved.

Only the scenarios can show the full rotation for all 32 counts in both directions. They drive walking-one and random words, interleave mixed counts and directions back to back with bubbles between them, and abandon words that are in flight when reset arrives mid-stream.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
package rot_pkg;
    // Direction encoding of the in_left port.
    typedef enum logic {
        ROT_RIGHT = 1'b0,
        ROT_LEFT  = 1'b1
    } rot_dir_e;
endpackage

// File: rtl/rot_bitrev.sv
`timescale 1ns/1ps
// Mirrors the bit order of a word: output bit i takes input bit W-1-i.
module rot_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/rot_stage.sv
`timescale 1ns/1ps
// One layer of the rotate tree: a 2:1 multiplexer row that rotates right
// by 2**LVL or passes the word through, with an optional output register.
module rot_stage
    import rot_pkg::*;
#(
    parameter int W          = 32,
    parameter int CW         = 5,
    parameter int LVL        = 0,
    parameter bit REGISTERED = 1'b1,
    parameter bit FINAL      = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [W-1:0]  in_word,
    input  logic [CW-1:0] in_cnt,
    input  rot_dir_e      in_dir,
    output logic          out_vld,
    output logic [W-1:0]  out_word,
    output logic [CW-1:0] out_cnt,
    output rot_dir_e      out_dir
);
    localparam int SHIFT = 1 << LVL;

    logic [W-1:0] rotated;
    logic [W-1:0] stage_word;

    always_comb begin
        if (in_cnt[LVL]) rotated = {in_word[SHIFT-1:0], in_word[W-1:SHIFT]};
        else             rotated = in_word;
    end

    if (FINAL) begin : g_unmirror
        logic [W-1:0] mirrored;
        rot_bitrev #(.W(W)) u_rev (.din(rotated), .dout(mirrored));
        assign stage_word = (in_dir == ROT_LEFT) ? mirrored : rotated;
    end else begin : g_plain
        assign stage_word = rotated;
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) out_vld <= 1'b0;
            else     out_vld <= in_vld;
            out_word <= stage_word;
            out_cnt  <= in_cnt;
            out_dir  <= in_dir;
        end
    end else begin : g_wire
        assign out_vld  = in_vld;
        assign out_word = stage_word;
        assign out_cnt  = in_cnt;
        assign out_dir  = in_dir;
    end
endmodule

// File: rtl/rot_barrel.sv
`timescale 1ns/1ps
// Log-depth barrel rotator: one 2:1 mux layer per count bit, left rotation
// by mirroring around the right-rotate chain, optional per-layer registers.
module rot_barrel
    import rot_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit PIPELINE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic [$clog2(DATA_W)-1:0]   in_count,
    input  logic                        in_left,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           out_data
);
    localparam int CNT_W   = $clog2(DATA_W);
    localparam int LATENCY = PIPELINE ? CNT_W : 1;

    logic              vld_s [CNT_W+1];
    logic [DATA_W-1:0] word_s [CNT_W+1];
    logic [CNT_W-1:0]  cnt_s [CNT_W+1];
    rot_dir_e          dir_s [CNT_W+1];

    logic [DATA_W-1:0] in_mirror;
    rot_bitrev #(.W(DATA_W)) u_in_rev (.din(in_data), .dout(in_mirror));

    assign vld_s[0]  = in_valid;
    assign word_s[0] = in_left ? in_mirror : in_data;
    assign cnt_s[0]  = in_count;
    assign dir_s[0]  = rot_dir_e'(in_left);

    for (genvar k = 0; k < CNT_W; k++) begin : g_layer
        rot_stage #(
            .W         (DATA_W),
            .CW        (CNT_W),
            .LVL       (k),
            .REGISTERED(PIPELINE || (k == CNT_W-1)),
            .FINAL     (k == CNT_W-1)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (vld_s[k]),
            .in_word (word_s[k]),
            .in_cnt  (cnt_s[k]),
            .in_dir  (dir_s[k]),
            .out_vld (vld_s[k+1]),
            .out_word(word_s[k+1]),
            .out_cnt (cnt_s[k+1]),
            .out_dir (dir_s[k+1])
        );
    end

    assign out_valid = vld_s[CNT_W];
    assign out_data  = word_s[CNT_W];
endmodule

// File: rtl/rot_barrel_chk.sv
`timescale 1ns/1ps
// Cycle-by-cycle checker; keeps delayed copies of the inputs for LAT edges.
module rot_barrel_chk #(
    parameter int W   = 32,
    parameter int CW  = 5,
    parameter int LAT = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [W-1:0]  in_data,
    input logic [CW-1:0] in_count,
    input logic          in_left,
    input logic          out_valid,
    input logic [W-1:0]  out_data
);
    logic         v_q  [LAT];
    logic         z_q  [LAT];
    logic         r1_q [LAT];
    logic         l1_q [LAT];
    logic [W-1:0] d_q  [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) v_q[i] <= 1'b0;
        end else begin
            v_q[0] <= in_valid;
            for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
        end
        d_q[0]  <= in_data;
        z_q[0]  <= (in_count == '0);
        r1_q[0] <= (in_count == CW'(1)) && !in_left;
        l1_q[0] <= (in_count == CW'(1)) && in_left;
        for (int i = 1; i < LAT; i++) begin
            d_q[i]  <= d_q[i-1];
            z_q[i]  <= z_q[i-1];
            r1_q[i] <= r1_q[i-1];
            l1_q[i] <= l1_q[i-1];
        end
    end

    p_reset_clear_r6: assert property (@(posedge clk) rst |=> !out_valid);

    p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_q[LAT-1]);

    p_zero_count_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && z_q[LAT-1]) |-> out_data == d_q[LAT-1]);

    p_right_one_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r1_q[LAT-1]) |-> out_data == {d_q[LAT-1][0], d_q[LAT-1][W-1:1]});

    p_left_one_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && l1_q[LAT-1]) |-> out_data == {d_q[LAT-1][W-2:0], d_q[LAT-1][W-1]});

    p_ones_kept_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(out_data) == $countones(d_q[LAT-1]));
endmodule

bind rot_barrel rot_barrel_chk #(.W(DATA_W), .CW(CNT_W), .LAT(LATENCY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_count (in_count),
    .in_left  (in_left),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/rot_barrel_test.sv
`timescale 1ns/1ps
module rot_barrel_test;
    localparam int W   = 32;
    localparam int CW  = 5;
    localparam int LAT = 5;

    typedef struct {
        logic [W-1:0] exp;
        int           due;
        string        rq;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [W-1:0]  in_data = '0;
    logic [CW-1:0] in_count = '0;
    logic          in_left = 1'b0;
    logic          out_valid;
    logic [W-1:0]  out_data;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rot_barrel #(.DATA_W(W), .PIPELINE(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_count(in_count), .in_left(in_left),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [W-1:0] ref_rot(logic [W-1:0] d, int n, bit left);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (left) r[(i + n) % W] = d[i];
            else      r[i] = d[(i + n) % W];
        end
        return r;
    endfunction

    task automatic check(bit ok, string rq, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", rq, act, exp, cyc);
        end
    endtask

    task automatic put(bit v, logic [W-1:0] d, int n, bit left);
        item_t it;
        @(negedge clk); #2;
        in_valid = v; in_data = d; in_count = CW'(n); in_left = left;
        if (v) begin
            it.exp = ref_rot(d, n, left);
            it.due = cyc + LAT;
            it.rq  = (n == 0) ? "R3" : (left ? "R2" : "R1");
            sb.push_back(it);
        end
    endtask

    // Monitor: compares each delivered result with the queue head.
    always @(negedge clk) begin
        item_t it;
        #1;
        if (!rst) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4 unexpected out_valid", {31'd0, out_valid}, '0);
                end else begin
                    it = sb.pop_front();
                    check(it.due == cyc, "R4 latency", W'(cyc), W'(it.due));
                    check(out_data == it.exp, it.rq, out_data, it.exp);
                    check($countones(out_data) == $countones(it.exp), "R7", out_data, it.exp);
                end
            end else if (sb.size() > 0 && sb[0].due == cyc) begin
                it = sb.pop_front();
                check(1'b0, "R4 missing result", '0, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        #1 check(out_valid == 1'b0, "R6 reset state", {31'd0, out_valid}, '0);
        @(negedge clk); #2 rst = 1'b0;

        // R1, R2, R3: every count, both directions, walking-one and random
        for (int dir = 0; dir < 2; dir++) begin
            for (int n = 0; n < W; n++) begin
                put(1'b1, W'(1) << ((n * 7 + 3) % W), n, dir[0]);
                put(1'b1, $urandom, n, dir[0]);
            end
        end

        // R5: back-to-back mixed words with bubbles, R4 bubble slots
        for (int j = 0; j < 60; j++) begin
            put((j % 3) != 2, $urandom, $urandom_range(0, W-1), $urandom_range(0, 1));
        end
        put(1'b1, 32'h8000_0001, 0, 1'b1);   // R3 left, zero count
        put(1'b1, 32'h8000_0001, 31, 1'b0);  // R1 boundary count
        put(1'b1, 32'h8000_0001, 31, 1'b1);  // R2 boundary count
        put(1'b0, '0, 0, 1'b0);
        repeat (LAT + 2) put(1'b0, $urandom, 0, 1'b0);

        // R6: reset with words in flight; none may appear afterwards
        for (int j = 0; j < 4; j++) put(1'b1, $urandom, j + 1, j[0]);
        @(negedge clk); #2;
        rst = 1'b1; in_valid = 1'b0; sb.delete();
        @(negedge clk); #1;
        check(out_valid == 1'b0, "R6 flush", {31'd0, out_valid}, '0);
        #1 rst = 1'b0;
        for (int j = 0; j < LAT + 2; j++) begin
            @(negedge clk); #1;
            check(out_valid == 1'b0, "R6 no stale word", {31'd0, out_valid}, '0);
        end

        // R5 after reset: alternating directions every cycle
        for (int j = 0; j < 16; j++) put(1'b1, $urandom, (j * 5) % W, j[0]);
        repeat (LAT + 3) put(1'b0, '0, 0, 1'b0);
        check(sb.size() == 0, "R4 all delivered", W'(sb.size()), '0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule